// File: doc/BRIEF.md
# Flash Window Dual-Map Redirect Decoder

This block sits beside the internal flash and the external chip-select logic. It watches each internal access and decides whether that access should go to an external memory region instead of the on-chip flash. The match window has a fixed shape. It has a run of leading zero bits, then a location field that says where the flash sits in the internal map, then a single gap bit, then a programmable base. The address type must also pass a masked compare.

On a hit from the internal core, three things happen. The flash is inhibited, a redirect request is raised, and the chosen chip-select number is given so that the bank's attributes are used. This holds even when that bank's own valid bit is clear. A hit from an external bus master cannot be served. It raises a transfer-error request instead.

The configuration is held in registers inside the block and loaded through a single write strobe. The enable bit takes its reset value from a reset configuration input. The outputs are combinational from that registered configuration and the current access, so they follow the address within the same cycle.

Top module: `dmap_remap`

## Requirements
- R1: After reset the enable takes the value of `boot_map_en`. The base is 0, the wide bit is 0 and the select is 000. The type field and the type mask are both 3'b001, where bit 0 is the data-space bit, so only accesses with `acc_type[0]`=1 match.
- R2: With `acc_addr_hi` bit 16 as the MSB and bit 0 as the LSB, a match needs all of the following. Bits 16..10 are zero. Bits 9..7 equal `map_loc`. Bit 6 is zero. Bits 5..0 equal the programmed base.
- R3: When the wide bit is set, bit 6 of `acc_addr_hi` is not compared, which doubles the window. When it is clear, bit 6 must be zero.
- R4: The type passes when `(acc_type ^ type_field) & type_mask` is zero. A mask of zero accepts every type.
- R5: For a select code 000 to 011, a matching internal access drives `flash_inhibit`=1 and `redirect_req`=1 in the same cycle, and `redirect_cs` equals the select's low two bits. No bank valid bit is consulted.
- R6: A select code of 1xx is reserved: `flash_inhibit`, `redirect_req` and `xfer_err` all stay 0 for any access.
- R7: With the enable clear, no output is raised for any access.
- R8: A matching access with `acc_ext_master`=1 drives `xfer_err`=1 and keeps `flash_inhibit` and `redirect_req` at 0.
- R9: The configuration registers load from the `cfg_*` inputs on a rising clock edge with `cfg_we`=1 and act from the next cycle. With `cfg_we`=0 they hold.
- R10: With `acc_valid`=0 all three request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_map_en | input | 1 | Reset value of the enable bit |
| cfg_we | input | 1 | Load strobe for the configuration |
| cfg_base | input | 6 | Programmable base bits |
| cfg_type | input | 3 | Address type to compare |
| cfg_type_mask | input | 3 | Type compare mask, 1 = compared |
| cfg_wide | input | 1 | Ignore the gap bit (double window) |
| cfg_sel | input | 3 | Target chip select, 1xx reserved |
| cfg_enable | input | 1 | Dual-map enable |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr_hi | input | 17 | Upper internal address bits |
| acc_type | input | 3 | Address type of the access |
| map_loc | input | 3 | Internal-map location of the flash |
| acc_ext_master | input | 1 | Access comes from an external master |
| flash_inhibit | output | 1 | Block the on-chip flash |
| redirect_req | output | 1 | Send the access to a chip-select region |
| redirect_cs | output | 2 | Target chip-select number |
| xfer_err | output | 1 | End the access with a transfer error |

## Verification
The bench builds the block with its default widths: seven leading zero bits, a three-bit location, a six-bit base and three-bit type and select fields. At these widths the whole 17-bit compare field is small enough to hit on purpose. Roughly half of the random addresses are built as exact window hits with one bit sometimes flipped, so every compare bit fails in turn. Each of the eight select codes and every type and mask pair is reached many times, and the external-master and disabled paths are mixed in as well.

// File: rtl/dmap_remap.sv
module dmap_remap #(
  parameter int LEAD_W = 7,
  parameter int LOC_W  = 3,
  parameter int BASE_W = 6,
  parameter int TYPE_W = 3,
  parameter int SEL_W  = 3,
  localparam int CMP_W = LEAD_W + LOC_W + 1 + BASE_W,
  localparam int CS_W  = SEL_W - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_map_en,
  input  logic              cfg_we,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [TYPE_W-1:0] cfg_type,
  input  logic [TYPE_W-1:0] cfg_type_mask,
  input  logic              cfg_wide,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic              cfg_enable,
  input  logic              acc_valid,
  input  logic [CMP_W-1:0]  acc_addr_hi,
  input  logic [TYPE_W-1:0] acc_type,
  input  logic [LOC_W-1:0]  map_loc,
  input  logic              acc_ext_master,
  output logic              flash_inhibit,
  output logic              redirect_req,
  output logic [CS_W-1:0]   redirect_cs,
  output logic              xfer_err
);

  localparam logic [TYPE_W-1:0] TYPE_RST = TYPE_W'(1);
  localparam int GAP_BIT = BASE_W;
  localparam int LOC_LO  = BASE_W + 1;

  logic [BASE_W-1:0] base_q;
  logic [TYPE_W-1:0] type_q, tmask_q;
  logic              wide_q, en_q;
  logic [SEL_W-1:0]  sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      type_q  <= TYPE_RST;
      tmask_q <= TYPE_RST;
      wide_q  <= 1'b0;
      sel_q   <= '0;
      en_q    <= boot_map_en;
    end else if (cfg_we) begin
      base_q  <= cfg_base;
      type_q  <= cfg_type;
      tmask_q <= cfg_type_mask;
      wide_q  <= cfg_wide;
      sel_q   <= cfg_sel;
      en_q    <= cfg_enable;
    end
  end

  logic lead_ok, loc_ok, gap_ok, base_ok, type_ok, sel_ok, hit;

  assign lead_ok = acc_addr_hi[CMP_W-1 -: LEAD_W] == '0;
  assign loc_ok  = acc_addr_hi[LOC_LO +: LOC_W] == map_loc;
  assign gap_ok  = wide_q | ~acc_addr_hi[GAP_BIT];
  assign base_ok = acc_addr_hi[BASE_W-1:0] == base_q;
  assign type_ok = ((acc_type ^ type_q) & tmask_q) == '0;
  assign sel_ok  = ~sel_q[SEL_W-1];

  assign hit = acc_valid & en_q & sel_ok & lead_ok & loc_ok & gap_ok & base_ok & type_ok;

  assign flash_inhibit = hit & ~acc_ext_master;
  assign redirect_req  = hit & ~acc_ext_master;
  assign redirect_cs   = sel_q[CS_W-1:0];
  assign xfer_err      = hit & acc_ext_master;

  AST_RSV_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q[SEL_W-1] |-> !flash_inhibit && !redirect_req && !xfer_err); // R6
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> !flash_inhibit && !redirect_req && !xfer_err); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid |-> !flash_inhibit && !redirect_req && !xfer_err); // R10
  AST_ERR_EXT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_err |-> acc_ext_master && !redirect_req && !flash_inhibit); // R8
  AST_REDIR_TYPE: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_req |-> ((acc_type ^ type_q) & tmask_q) == '0); // R4
  AST_REDIR_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_req |-> acc_addr_hi[CMP_W-1 -: LEAD_W] == '0); // R2
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> $stable(sel_q) && $stable(en_q) && $stable(base_q) && $stable(wide_q)); // R9

endmodule

// File: tb/dmap_remap_tb.sv
`timescale 1ns/1ps
module dmap_remap_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic boot_map_en = 1'b1;
  logic cfg_we = 1'b0;
  logic [5:0] cfg_base = '0;
  logic [2:0] cfg_type = '0, cfg_type_mask = '0, cfg_sel = '0;
  logic cfg_wide = 1'b0, cfg_enable = 1'b0;
  logic acc_valid = 1'b0;
  logic [16:0] acc_addr_hi = '0;
  logic [2:0] acc_type = '0, map_loc = '0;
  logic acc_ext_master = 1'b0;
  logic flash_inhibit, redirect_req, xfer_err;
  logic [1:0] redirect_cs;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [5:0] m_base;
  logic [2:0] m_type, m_mask, m_sel;
  logic m_wide, m_en;

  always #2 clk = ~clk;

  dmap_remap u_dut (
    .clk(clk), .rst_n(rst_n), .boot_map_en(boot_map_en), .cfg_we(cfg_we),
    .cfg_base(cfg_base), .cfg_type(cfg_type), .cfg_type_mask(cfg_type_mask),
    .cfg_wide(cfg_wide), .cfg_sel(cfg_sel), .cfg_enable(cfg_enable),
    .acc_valid(acc_valid), .acc_addr_hi(acc_addr_hi), .acc_type(acc_type),
    .map_loc(map_loc), .acc_ext_master(acc_ext_master),
    .flash_inhibit(flash_inhibit), .redirect_req(redirect_req),
    .redirect_cs(redirect_cs), .xfer_err(xfer_err));

  function automatic logic [4:0] expect_out(logic v, logic [16:0] a, logic [2:0] t,
                                            logic [2:0] loc, logic ext);
    logic match;
    match = v && m_en && !m_sel[2] && a[16:10] == 7'd0 && a[9:7] == loc
            && (m_wide || !a[6]) && a[5:0] == m_base && ((t ^ m_type) & m_mask) == 3'd0;
    return {match && !ext, match && !ext, m_sel[1:0], match && ext};
  endfunction

  function automatic logic [16:0] make_addr(logic [2:0] loc, logic gap, logic [5:0] b);
    return {7'd0, loc, gap, b};
  endfunction

  task automatic check(string req);
    logic [4:0] exp, act;
    exp = expect_out(acc_valid, acc_addr_hi, acc_type, map_loc, acc_ext_master);
    act = {flash_inhibit, redirect_req, redirect_cs, xfer_err};
    if (!exp[4] && !exp[3]) begin
      act[2:1] = 2'b00;
      exp[2:1] = 2'b00;
    end
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: inh/req/cs/err actual=%b expected=%b addr=%h type=%b loc=%b ext=%b",
               req, act, exp, acc_addr_hi, acc_type, map_loc, acc_ext_master);
    end
  endtask

  task automatic apply(logic v, logic [16:0] a, logic [2:0] t, logic [2:0] loc,
                       logic ext, string req);
    acc_valid = v; acc_addr_hi = a; acc_type = t; map_loc = loc; acc_ext_master = ext;
    #1;
    check(req);
  endtask

  task automatic write_cfg(logic [5:0] b, logic [2:0] t, logic [2:0] m, logic w,
                           logic [2:0] s, logic e);
    cfg_base = b; cfg_type = t; cfg_type_mask = m; cfg_wide = w; cfg_sel = s; cfg_enable = e;
    cfg_we = 1'b1;
    @(posedge clk); #1;
    cfg_we = 1'b0;
    m_base = b; m_type = t; m_mask = m; m_wide = w; m_sel = s; m_en = e;
  endtask

  task automatic do_reset(logic boot);
    boot_map_en = boot;
    rst_n = 1'b0;
    @(posedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    m_base = 6'd0; m_type = 3'b001; m_mask = 3'b001; m_wide = 1'b0; m_sel = 3'd0; m_en = boot;
  endtask

  initial begin
    do_reset(1'b1);
    // R1: reset config maps data accesses at base 0, bank 0
    apply(1, make_addr(3'd0, 0, 6'd0), 3'b001, 3'd0, 0, "R1");
    if (redirect_req !== 1'b1) begin failures++; $display("FAIL R1: redirect actual=%b expected=1", redirect_req); end
    checks++;
    apply(1, make_addr(3'd0, 0, 6'd0), 3'b110, 3'd0, 0, "R1 R4");
    apply(0, make_addr(3'd0, 0, 6'd0), 3'b001, 3'd0, 0, "R10");
    // R9: staged config not visible until write edge
    cfg_base = 6'h2A; cfg_sel = 3'd3; cfg_enable = 1'b1; cfg_type_mask = 3'd0;
    @(posedge clk); #1;
    apply(1, make_addr(3'd0, 0, 6'd0), 3'b001, 3'd0, 0, "R9 hold");
    write_cfg(6'h2A, 3'd0, 3'd0, 0, 3'd3, 1);
    apply(1, make_addr(3'd5, 0, 6'h2A), 3'b111, 3'd5, 0, "R9 R5");
    apply(1, make_addr(3'd5, 1, 6'h2A), 3'b111, 3'd5, 0, "R3 narrow");
    apply(1, make_addr(3'd5, 0, 6'h2A), 3'b111, 3'd4, 0, "R2 loc");
    apply(1, make_addr(3'd5, 0, 6'h2A) | 17'h10000, 3'b111, 3'd5, 0, "R2 lead");
    apply(1, make_addr(3'd5, 0, 6'h2A), 3'b000, 3'd5, 1, "R8");
    write_cfg(6'h15, 3'd0, 3'd0, 1, 3'd2, 1);
    apply(1, make_addr(3'd1, 1, 6'h15), 3'b010, 3'd1, 0, "R3 wide");
    write_cfg(6'h15, 3'd0, 3'd0, 1, 3'd5, 1);
    apply(1, make_addr(3'd1, 1, 6'h15), 3'b010, 3'd1, 0, "R6");
    apply(1, make_addr(3'd1, 1, 6'h15), 3'b010, 3'd1, 1, "R6 ext");
    write_cfg(6'h15, 3'd0, 3'd0, 1, 3'd1, 0);
    apply(1, make_addr(3'd1, 1, 6'h15), 3'b010, 3'd1, 0, "R7");
    do_reset(1'b0);
    apply(1, make_addr(3'd0, 0, 6'd0), 3'b001, 3'd0, 0, "R1 boot off");

    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] loc;
      logic [16:0] a;
      if ($urandom_range(0, 9) == 0)
        write_cfg(6'($urandom), 3'($urandom), 3'($urandom), 1'($urandom),
                  3'($urandom), $urandom_range(0, 7) != 0);
      loc = 3'($urandom);
      if ($urandom_range(0, 1) == 0) begin
        a = make_addr(loc, m_wide ? 1'($urandom) : 1'b0, m_base);
        if ($urandom_range(0, 3) == 0) a = a ^ (17'd1 << $urandom_range(0, 16));
      end else begin
        a = 17'($urandom);
      end
      apply($urandom_range(0, 7) != 0, a, 3'($urandom), loc, $urandom_range(0, 4) == 0,
            "R2 R3 R4 R5 R6 R7 R8 R10 random");
      @(posedge clk); #1;
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule